// File: doc/BRIEF.md
# Overlay configurable logic block

This block is one soft logic cell for an overlay fabric built on top of a host programmable device. Many copies are placed in a grid. Each copy takes three 4-bit groups of input wires. Each group feeds its own programmable 4-input lookup table. Two output paths choose among the three table results, or their majority. The local path drives `f_out` and the global path drives `g_out`. Each path can present its choice straight through or through its own positive-edge D flip-flop.

All configuration lives in a 54-bit shift register. While `cfg_en` is high, the register takes one bit from `cfg_in` on each clock, and its top bit appears on `cfg_out`. Cells can therefore be chained serially and reprogrammed at run time, as often as wanted. During shifting both outputs are held at 0, so a half-loaded chain cannot close a combinational loop through the fabric. The flip-flops keep their values across a reload.

Reset is asynchronous and active-low on `rst_n`. It is released inside the cell through a two-stage synchronizer.

Top module: `olcb_cell`

## Requirements
- R1: While `cfg_en` is high, each rising clock moves the configuration word one place toward the top (bit 0 takes `cfg_in`). `cfg_out` always shows bit 53, so a bit fed in at the first of 54 shifts ends at bit 53, and after 54 more shifts it has left through `cfg_out`.
- R2: While `cfg_en` is low, the configuration word, and therefore `cfg_out`, does not change.
- R3: Each table result equals bit `{in3,in2,in1,in0}` of its 16-bit field. Table A (`a_in`) uses word bits 15:0, table B (`b_in`) uses bits 31:16 and table C (`c_in`) uses bits 47:32.
- R4: A 2-bit source code picks the path value: 0 is table A, 1 is table B, 2 is table C, 3 is the majority of the three table results.
- R5: A mode bit of 1 makes the path output the flip-flop value, which holds the source value captured at the previous rising edge. A mode bit of 0 makes the path output the source value combinationally.
- R6: The two paths have independent fields. The local path uses source code bits 49:48 and mode bit 52. The global path uses source code bits 51:50 and mode bit 53.
- R7: While `cfg_en` is high, `f_out` and `g_out` are both 0.
- R8: While `cfg_en` is high, both flip-flops keep their values. After `cfg_en` falls, a registered output first shows the value held from before the reload.
- R9: While reset is active, the flip-flops and the configuration word are 0. The cell leaves reset at the second rising edge after `rst_n` rises, and flip-flops first capture at the third.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Configuration shift enable; gates outputs to 0 |
| cfg_in | input | 1 | Serial configuration data in |
| cfg_out | output | 1 | Serial configuration data out (top bit of the word) |
| a_in | input | 4 | Inputs of table A |
| b_in | input | 4 | Inputs of table B |
| c_in | input | 4 | Inputs of table C |
| f_out | output | 1 | Local output |
| g_out | output | 1 | Global output |

## Verification
The bench loads several words that give the two paths different sources and modes. It then drives random inputs, so a swapped field, a wrong table index or a wrong majority shows up as a mismatched output bit. It reloads while registered values are nonzero and stretches the shift with idle gaps. A design that clocked its flip-flops during shifting, kept shifting with `cfg_en` low, or did not gate its outputs would then show a wrong bit on an output or on `cfg_out`. The shifted-out stream of the old word is also compared bit by bit, which exposes an off-by-one in the chain or a reversed order.

// File: rtl/olcb_pkg.sv
package olcb_pkg;
  typedef enum logic [1:0] {
    SRC_A   = 2'd0,
    SRC_B   = 2'd1,
    SRC_C   = 2'd2,
    SRC_MAJ = 2'd3
  } src_e;

  function automatic logic maj3(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction
endpackage

// File: rtl/olcb_rst_sync.sv
module olcb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/olcb_cfg_chain.sv
module olcb_cfg_chain #(
  parameter int W = 54
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         sin,
  output logic [W-1:0] word_q,
  output logic         sout
);
  logic [W-1:0] word_d;

  always_comb begin
    word_d = word_q;
    if (shift_en) word_d = {word_q[W-2:0], sin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign sout = word_q[W-1];
endmodule

// File: rtl/olcb_lut.sv
module olcb_lut #(
  parameter int K = 4,
  localparam int N = 1 << K
) (
  input  logic [N-1:0] table_bits,
  input  logic [K-1:0] idx,
  output logic         y
);
  assign y = table_bits[idx];
endmodule

// File: rtl/olcb_out_path.sv
module olcb_out_path
  import olcb_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic [2:0]       lut_y,
  input  logic [SEL_W-1:0] sel,
  input  logic             use_reg,
  output logic             q,
  output logic             y
);
  logic comb_v;
  logic q_d;

  always_comb begin
    unique case (src_e'(sel))
      SRC_A:   comb_v = lut_y[0];
      SRC_B:   comb_v = lut_y[1];
      SRC_C:   comb_v = lut_y[2];
      default: comb_v = maj3(lut_y[0], lut_y[1], lut_y[2]);
    endcase
  end

  always_comb begin
    q_d = q;
    if (!hold) q_d = comb_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_d;
  end

  assign y = hold ? 1'b0 : (use_reg ? q : comb_v);
endmodule

// File: rtl/olcb_cell.sv
module olcb_cell #(
  parameter int LUT_K = 4,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             cfg_in,
  output logic             cfg_out,
  input  logic [LUT_K-1:0] a_in,
  input  logic [LUT_K-1:0] b_in,
  input  logic [LUT_K-1:0] c_in,
  output logic             f_out,
  output logic             g_out
);
  localparam int N_LUT    = 3;
  localparam int N_PATH   = 2;
  localparam int LUT_BITS = 1 << LUT_K;
  localparam int SEL_BASE = N_LUT * LUT_BITS;
  localparam int REG_BASE = SEL_BASE + N_PATH * SEL_W;
  localparam int CFG_W    = REG_BASE + N_PATH;

  logic                         rst_i;
  logic [CFG_W-1:0]             cfg_q;
  logic [N_LUT-1:0][LUT_K-1:0]  lut_in;
  logic [N_LUT-1:0]             lut_y;
  logic [N_PATH-1:0]            ffq;
  logic [N_PATH-1:0]            path_y;

  olcb_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i)
  );

  olcb_cfg_chain #(.W(CFG_W)) u_chain (
    .clk      (clk),
    .rst_n    (rst_i),
    .shift_en (cfg_en),
    .sin      (cfg_in),
    .word_q   (cfg_q),
    .sout     (cfg_out)
  );

  assign lut_in = {c_in, b_in, a_in};

  for (genvar i = 0; i < N_LUT; i++) begin : g_lut
    olcb_lut #(.K(LUT_K)) u_lut (
      .table_bits (cfg_q[i*LUT_BITS +: LUT_BITS]),
      .idx        (lut_in[i]),
      .y          (lut_y[i])
    );
  end

  for (genvar p = 0; p < N_PATH; p++) begin : g_path
    olcb_out_path #(.SEL_W(SEL_W)) u_path (
      .clk     (clk),
      .rst_n   (rst_i),
      .hold    (cfg_en),
      .lut_y   (lut_y),
      .sel     (cfg_q[SEL_BASE + p*SEL_W +: SEL_W]),
      .use_reg (cfg_q[REG_BASE + p]),
      .q       (ffq[p]),
      .y       (path_y[p])
    );
  end

  assign f_out = path_y[0];
  assign g_out = path_y[1];
endmodule

// File: rtl/olcb_cell_chk.sv
module olcb_cell_chk #(
  parameter int CFG_W = 54
) (
  input logic             clk,
  input logic             rst_i,
  input logic             cfg_en,
  input logic             cfg_in,
  input logic             cfg_out,
  input logic             f_out,
  input logic             g_out,
  input logic [CFG_W-1:0] cfg_q,
  input logic [1:0]       ffq
);
  p_shift_in_r1: assert property (@(posedge clk) disable iff (!rst_i)
    cfg_en |=> cfg_q[0] == $past(cfg_in));
  p_shift_out_r1: assert property (@(posedge clk) disable iff (!rst_i)
    cfg_en |=> cfg_out == $past(cfg_q[CFG_W-2]));
  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_i)
    !cfg_en |=> $stable(cfg_q));
  p_regmode_r5: assert property (@(posedge clk) disable iff (!rst_i)
    (!cfg_en && cfg_q[CFG_W-2]) |-> f_out == ffq[0]);
  p_regmode_g_r6: assert property (@(posedge clk) disable iff (!rst_i)
    (!cfg_en && cfg_q[CFG_W-1]) |-> g_out == ffq[1]);
  p_gate_r7: assert property (@(posedge clk) disable iff (!rst_i)
    cfg_en |-> (!f_out && !g_out));
  p_ff_hold_r8: assert property (@(posedge clk) disable iff (!rst_i)
    cfg_en |=> $stable(ffq));
  p_reset_r9: assert property (@(posedge clk)
    !rst_i |-> (ffq == 2'b00 && cfg_q == '0));
endmodule

bind olcb_cell olcb_cell_chk #(.CFG_W(CFG_W)) u_chk (
  .clk     (clk),
  .rst_i   (rst_i),
  .cfg_en  (cfg_en),
  .cfg_in  (cfg_in),
  .cfg_out (cfg_out),
  .f_out   (f_out),
  .g_out   (g_out),
  .cfg_q   (cfg_q),
  .ffq     (ffq)
);

// File: tb/sim_olcb_cell.sv
module sim_olcb_cell;
  localparam int CLK_PERIOD = 10;
  localparam int W = 54;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic cfg_en = 1'b0;
  logic cfg_in = 1'b0;
  logic [3:0] a_in = '0, b_in = '0, c_in = '0;
  logic cfg_out, f_out, g_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  string tag_f = "R9";
  string tag_g = "R9";

  // reference model state
  logic [W-1:0] m_cfg = '0;
  logic m_ff_f = 1'b0, m_ff_g = 1'b0;
  int   m_rel = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  olcb_cell u0 (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_in(cfg_in),
    .cfg_out(cfg_out), .a_in(a_in), .b_in(b_in), .c_in(c_in),
    .f_out(f_out), .g_out(g_out)
  );

  function automatic logic src_val(input logic [W-1:0] w, input int code,
                                   input logic [3:0] a, input logic [3:0] b,
                                   input logic [3:0] c);
    logic va, vb, vc;
    va = w[int'(a)];
    vb = w[16 + int'(b)];
    vc = w[32 + int'(c)];
    case (code)
      0: return va;
      1: return vb;
      2: return vc;
      default: return (int'(va) + int'(vb) + int'(vc)) >= 2;
    endcase
  endfunction

  function automatic logic exp_f();
    logic v;
    v = src_val(m_cfg, int'(m_cfg[49:48]), a_in, b_in, c_in);
    if (cfg_en) return 1'b0;
    return m_cfg[52] ? m_ff_f : v;
  endfunction

  function automatic logic exp_g();
    logic v;
    v = src_val(m_cfg, int'(m_cfg[51:50]), a_in, b_in, c_in);
    if (cfg_en) return 1'b0;
    return m_cfg[53] ? m_ff_g : v;
  endfunction

  always @(posedge clk) begin
    logic vf, vg;
    if (!rst_n) begin
      m_rel = 0; m_cfg = '0; m_ff_f = 1'b0; m_ff_g = 1'b0;
    end else if (m_rel < 2) begin
      m_rel = m_rel + 1;
    end else begin
      vf = src_val(m_cfg, int'(m_cfg[49:48]), a_in, b_in, c_in);
      vg = src_val(m_cfg, int'(m_cfg[51:50]), a_in, b_in, c_in);
      if (cfg_en) m_cfg = {m_cfg[W-2:0], cfg_in};
      else begin m_ff_f = vf; m_ff_g = vg; end
    end
  end

  task automatic check(input string req, input string what,
                       input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check(cfg_en ? "R7" : tag_f, "f_out", f_out, exp_f());
      check(cfg_en ? "R7" : tag_g, "g_out", g_out, exp_g());
      check(cfg_en ? "R1" : "R2", "cfg_out", cfg_out, m_cfg[W-1]);
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic load(input logic [W-1:0] w, input bit gaps);
    for (int i = W-1; i >= 0; i--) begin
      cfg_en = 1'b1; cfg_in = w[i];
      a_in = 4'($urandom); b_in = 4'($urandom); c_in = 4'($urandom);
      step();
      if (gaps && (i % 9 == 0)) begin
        cfg_en = 1'b0; cfg_in = ~cfg_in;
        step();
      end
    end
    cfg_en = 1'b0; cfg_in = 1'b0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      a_in = 4'($urandom); b_in = 4'($urandom); c_in = 4'($urandom);
      step();
    end
  endtask

  function automatic logic [W-1:0] mk(input logic gr, input logic fr,
                                       input logic [1:0] gs, input logic [1:0] fs,
                                       input logic [15:0] c, input logic [15:0] b,
                                       input logic [15:0] a);
    return {gr, fr, gs, fs, c, b, a};
  endfunction

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) step();
    tag_f = "R9"; tag_g = "R9";
    rst_n = 1'b1;
    repeat (3) step();
    // R3 R4 R6: F = table A combinational, G = table B registered (R5)
    load(mk(1'b1, 1'b0, 2'd1, 2'd0, 16'hFFFE, 16'h6996, 16'h8001), 1'b0);
    tag_f = "R8"; tag_g = "R8";
    step();
    tag_f = "R3"; tag_g = "R5";
    run(60);
    // R8 reload with gaps while registers hold values; F = C registered, G = majority comb
    load(mk(1'b0, 1'b1, 2'd3, 2'd2, 16'h3C5A, 16'hF00F, 16'h00FF), 1'b1);
    tag_f = "R8"; tag_g = "R4";
    step();
    tag_f = "R5"; tag_g = "R4";
    run(60);
    // R6 both paths on majority, F registered, G combinational, different tables
    load(mk(1'b0, 1'b1, 2'd3, 2'd3, 16'hAAAA, 16'hCCCC, 16'hF0F0), 1'b0);
    tag_f = "R6"; tag_g = "R4";
    run(60);
    // R6 F = table B comb, G = table A registered
    load(mk(1'b1, 1'b0, 2'd0, 2'd1, 16'h1234, 16'h5678, 16'h9ABC), 1'b1);
    tag_f = "R6"; tag_g = "R6";
    run(60);
    // R1 flush the word out through cfg_out
    load('0, 1'b0);
    tag_f = "R2"; tag_g = "R2";
    run(10);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end
endmodule